// File: doc/BRIEF.md
# Shared Bus Admission Controller with Ordered Retry

This block decides, cycle by cycle, whether a transfer attempt from one of several ports may start on a shared bus. It keeps a count of the core cycles for which the bus stays occupied. A transfer is accepted only when three things hold: the bus is free, the destination is ready, and no other port is waiting ahead of the requester. Every other attempt is rejected, and the rejected port joins an in-order retry queue.

When the bus falls idle and ports are waiting, only the port at the queue head gets a one-cycle retry strobe. That port may resend in the very next cycle. It leaves the queue if it succeeds or stays silent. If its resend is rejected again, it keeps its place at the head. The bus clock is a fixed divisor of the core clock. Each transfer is first aligned to a bus-cycle boundary. It then holds the bus for a number of bus cycles that depends on its kind and its byte length.

Top module: `shbus_admit`

## Requirements
- R1: An attempt made while `busy_o` is high is rejected in the same cycle, and the port is queued if it is not already waiting.
- R2: While the retry queue holds any port, an attempt from a port that is not in its post-strobe resend window is rejected.
- R3: An attempt made while `dst_rdy_i` is low is rejected and the port is queued if not already waiting; this includes a resend inside the window.
- R4: An accepted request (`att_req_i` = 1) occupies one bus cycle, whatever its data and size flags.
- R5: An accepted non-request with data (`att_dat_i` = 1) occupies ceil(size / (WIDTH_BITS/8)) bus cycles. An accepted response with no data occupies one bus cycle.
- R6: Occupancy starts at a bus-cycle boundary. With phase p in 0..DIV-1, counted in core cycles since reset, an accept at p = 0 adds no padding and an accept at p ≠ 0 adds DIV-p core cycles. `busy_o` then stays high for exactly that padding plus the bus cycles times DIV.
- R7: `retry_o` is one-hot or zero, is never high for two cycles in a row, appears only while `busy_o` is low, and names only the queue head.
- R8: A strobed port that resends in the next cycle, with the bus idle and `dst_rdy_i` high, is accepted and leaves the queue.
- R9: A strobed port that does not resend in the next cycle leaves the queue head, and the next waiter (if any) is strobed once the bus is idle.
- R10: A strobed port whose resend is rejected stays at the queue head and is strobed again before any later waiter.
- R11: The queue is first-in first-out and never holds one port twice. A repeated attempt from a waiting port is rejected without adding a second entry.
- R12: For the attempting port exactly one of `acc_o` and `rej_o` is set in that cycle, and neither is set for any other port.
- R13: After reset the bus is idle, the queue is empty and no strobe is issued. `busy_o` is high exactly while occupancy cycles remain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| att_vld_i | input | NPORT | Per-port transfer attempt |
| att_req_i | input | NPORT | Attempt is a request (address phase) |
| att_rsp_i | input | NPORT | Attempt is a response |
| att_dat_i | input | NPORT | Attempt carries data |
| att_size_i | input | NPORT*SZ_W | Per-port byte length, port p in bits [p*SZ_W +: SZ_W] |
| dst_rdy_i | input | 1 | Destination can take the transfer |
| acc_o | output | NPORT | Attempt accepted, one-hot |
| rej_o | output | NPORT | Attempt rejected, one-hot |
| retry_o | output | NPORT | One-cycle retry strobe to the queue head |
| busy_o | output | 1 | Bus occupied |

## Verification
The checker assumes that at most one port asserts `att_vld_i` in any cycle. Attempts reach the controller one at a time, and the lowest-index port would otherwise win silently. The bench's single drive task clears every port before raising the one it needs, so the assumption always holds. Attribute flags and sizes are held stable with `att_vld_i` for the whole cycle. The bench drives them only at the falling edge, and it tracks the bus-cycle phase with its own counter so that padding expectations come from the requirement alone.

// File: rtl/shbus_pkg.sv
package shbus_pkg;

    // Kind flags of one transfer attempt.
    typedef struct packed {
        logic is_req;
        logic is_rsp;
        logic has_dat;
    } shbus_attr_t;

    // Bus cycles an accepted transfer needs (R4, R5).
    function automatic logic [15:0] shbus_beats(input shbus_attr_t a,
                                                input logic [15:0] size_b,
                                                input int          lane_b);
        logic [31:0] t;
        t = '0;
        if (a.is_req)
            t = 32'd1;
        else if (a.has_dat)
            t = (32'(size_b) + 32'(lane_b) - 32'd1) / 32'(lane_b);
        else if (a.is_rsp)
            t = 32'd1;
        return t[15:0];
    endfunction

endpackage

// File: rtl/shbus_occupancy.sv
module shbus_occupancy #(
    parameter int DIV   = 2,
    parameter int OCC_W = 18
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [15:0] beats,
    output logic        idle,
    output logic        busy
);
    localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PH_W-1:0]  ph;
    logic [OCC_W-1:0] occ, occ_n, pad, add;

    // Core-cycle phase inside one bus cycle.
    generate
        if (DIV > 1) begin : g_phase
            always_ff @(posedge clk) begin
                if (rst)
                    ph <= '0;
                else if (ph == PH_W'(DIV - 1))
                    ph <= '0;
                else
                    ph <= ph + 1'b1;
            end
        end else begin : g_nophase
            assign ph = '0;
        end
    endgenerate

    // R6: align to the next boundary before adding occupancy.
    always_comb begin
        pad = (ph == '0) ? '0 : (OCC_W'(DIV) - OCC_W'(ph));
        add = pad + OCC_W'(beats) * OCC_W'(DIV);
        occ_n = (occ != '0) ? (occ - 1'b1) : '0;
        if (load)
            occ_n = occ_n + add;
    end

    always_ff @(posedge clk) begin
        if (rst)
            occ <= '0;
        else
            occ <= occ_n;
    end

    assign idle = (occ == '0);
    assign busy = !idle;
endmodule

// File: rtl/shbus_retry_queue.sv
module shbus_retry_queue #(
    parameter int N   = 4,
    parameter int IDW = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           push,
    input  logic [IDW-1:0] push_id,
    input  logic           pop,
    output logic [IDW-1:0] head_id,
    output logic           empty,
    output logic [N-1:0]   queued
);
    localparam int CW = $clog2(N + 1);

    logic [IDW-1:0] q  [N];
    logic [IDW-1:0] qn [N];
    logic [CW-1:0]  cnt, cn;

    always_comb begin
        qn = q;
        cn = cnt;
        if (pop && cnt != '0) begin
            for (int i = 0; i < N - 1; i++)
                qn[i] = q[i + 1];
            cn = cnt - 1'b1;
        end
        if (push && cn < CW'(N)) begin
            for (int i = 0; i < N; i++)
                if (CW'(i) == cn)
                    qn[i] = push_id;
            cn = cn + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            for (int i = 0; i < N; i++)
                q[i] <= '0;
        end else begin
            cnt <= cn;
            q   <= qn;
        end
    end

    // Membership map used to keep entries unique (R11).
    always_comb begin
        queued = '0;
        for (int i = 0; i < N; i++)
            if (CW'(i) < cnt)
                queued[q[i]] = 1'b1;
    end

    assign head_id = q[0];
    assign empty   = (cnt == '0);
endmodule

// File: rtl/shbus_admit.sv
module shbus_admit
    import shbus_pkg::*;
#(
    parameter int NPORT      = 4,
    parameter int WIDTH_BITS = 64,
    parameter int DIV        = 2,
    parameter int SZ_W       = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NPORT-1:0]      att_vld_i,
    input  logic [NPORT-1:0]      att_req_i,
    input  logic [NPORT-1:0]      att_rsp_i,
    input  logic [NPORT-1:0]      att_dat_i,
    input  logic [NPORT*SZ_W-1:0] att_size_i,
    input  logic                  dst_rdy_i,
    output logic [NPORT-1:0]      acc_o,
    output logic [NPORT-1:0]      rej_o,
    output logic [NPORT-1:0]      retry_o,
    output logic                  busy_o
);
    localparam int IDW    = (NPORT > 1) ? $clog2(NPORT) : 1;
    localparam int LANE_B = WIDTH_BITS / 8;
    localparam int OCC_W  = 16 + $clog2(DIV + 1) + 1;

    logic              att_any;
    logic [IDW-1:0]    att_id;
    shbus_attr_t       attr;
    logic [SZ_W-1:0]   att_size;
    logic [15:0]       beats;
    logic              idle, busy;
    logic              win_q, gid_ok, admit, reject, strobe, push, pop;
    logic [IDW-1:0]    gid_q, head_id;
    logic              q_empty;
    logic [NPORT-1:0]  queued;

    // Pick the attempting port (at most one is expected).
    always_comb begin
        att_any = 1'b0;
        att_id  = '0;
        for (int i = NPORT - 1; i >= 0; i--)
            if (att_vld_i[i]) begin
                att_any = 1'b1;
                att_id  = IDW'(i);
            end
    end

    always_comb begin
        attr.is_req  = att_req_i[att_id];
        attr.is_rsp  = att_rsp_i[att_id];
        attr.has_dat = att_dat_i[att_id];
        att_size     = att_size_i[att_id*SZ_W +: SZ_W];
        beats        = shbus_beats(attr, 16'(att_size), LANE_B);
    end

    // R1, R2, R3: admission rule.
    assign gid_ok = win_q && (att_id == gid_q);
    assign admit  = att_any && idle && (q_empty || gid_ok) && dst_rdy_i;
    assign reject = att_any && !admit;

    // R11: a waiting port is not queued again.
    assign push   = reject && !queued[att_id];
    // R8, R9, R10: head leaves unless its resend was turned down.
    assign pop    = win_q && !(gid_ok && reject);
    // R7: strobe the head once the bus is idle.
    assign strobe = idle && !q_empty && !win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= 1'b0;
            gid_q <= '0;
        end else begin
            win_q <= strobe;
            if (strobe)
                gid_q <= head_id;
        end
    end

    shbus_occupancy #(
        .DIV   (DIV),
        .OCC_W (OCC_W)
    ) u_occ (
        .clk   (clk),
        .rst   (rst),
        .load  (admit),
        .beats (beats),
        .idle  (idle),
        .busy  (busy)
    );

    shbus_retry_queue #(
        .N   (NPORT),
        .IDW (IDW)
    ) u_rtq (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .push_id (att_id),
        .pop     (pop),
        .head_id (head_id),
        .empty   (q_empty),
        .queued  (queued)
    );

    assign acc_o   = admit  ? (NPORT'(1) << att_id)  : '0;
    assign rej_o   = reject ? (NPORT'(1) << att_id)  : '0;
    assign retry_o = strobe ? (NPORT'(1) << head_id) : '0;
    assign busy_o  = busy;
endmodule

// File: rtl/shbus_admit_chk.sv
module shbus_admit_chk #(
    parameter int NPORT = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [NPORT-1:0] att_vld_i,
    input logic [NPORT-1:0] att_req_i,
    input logic             dst_rdy_i,
    input logic [NPORT-1:0] acc_o,
    input logic [NPORT-1:0] rej_o,
    input logic [NPORT-1:0] retry_o,
    input logic             busy_o
);
    // Input assumption: one attempt per cycle (R12).
    a_r12_single_attempt: assert property (@(posedge clk) disable iff (rst)
        $onehot0(att_vld_i));

    a_r12_one_answer: assert property (@(posedge clk) disable iff (rst)
        ((acc_o & rej_o) == '0) && (((acc_o | rej_o) & ~att_vld_i) == '0)
        && ((acc_o | rej_o) == att_vld_i));

    a_r1_idle_only: assert property (@(posedge clk) disable iff (rst)
        (acc_o != '0) |-> !busy_o);

    a_r2_grant_only: assert property (@(posedge clk) disable iff (rst)
        (retry_o != '0) |=> ((acc_o & ~$past(retry_o)) == '0));

    a_r3_dst_block: assert property (@(posedge clk) disable iff (rst)
        !dst_rdy_i |-> (acc_o == '0));

    a_r4_req_busy: assert property (@(posedge clk) disable iff (rst)
        ((acc_o & att_req_i) != '0) |=> busy_o);

    a_r7_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(retry_o));

    a_r7_pulse: assert property (@(posedge clk) disable iff (rst)
        (retry_o != '0) |=> (retry_o == '0));

    a_r7_idle: assert property (@(posedge clk) disable iff (rst)
        (retry_o != '0) |-> !busy_o);
endmodule

bind shbus_admit shbus_admit_chk #(.NPORT(NPORT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .att_vld_i (att_vld_i),
    .att_req_i (att_req_i),
    .dst_rdy_i (dst_rdy_i),
    .acc_o     (acc_o),
    .rej_o     (rej_o),
    .retry_o   (retry_o),
    .busy_o    (busy_o)
);

// File: tb/shbus_admit_bench.sv
module shbus_admit_bench;
    localparam int NP   = 4;
    localparam int DIV  = 2;
    localparam int SZW  = 8;

    typedef struct packed {
        logic       rq;
        logic       rs;
        logic       dt;
        logic [7:0] sz;
        logic [7:0] beats;
    } vec_t;

    // Lane of 8 bytes: beats follow R4 / R5.
    localparam vec_t TBL [10] = '{
        '{1'b1, 1'b0, 1'b0, 8'd0,   8'd1},
        '{1'b1, 1'b0, 1'b1, 8'd64,  8'd1},
        '{1'b0, 1'b1, 1'b1, 8'd64,  8'd8},
        '{1'b0, 1'b1, 1'b1, 8'd65,  8'd9},
        '{1'b0, 1'b1, 1'b1, 8'd1,   8'd1},
        '{1'b0, 1'b1, 1'b0, 8'd0,   8'd1},
        '{1'b0, 1'b0, 1'b1, 8'd16,  8'd2},
        '{1'b0, 1'b1, 1'b1, 8'd255, 8'd32},
        '{1'b0, 1'b1, 1'b1, 8'd8,   8'd1},
        '{1'b0, 1'b1, 1'b1, 8'd9,   8'd2}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NP-1:0]     att_vld = '0, att_req = '0, att_rsp = '0, att_dat = '0;
    logic [NP*SZW-1:0] att_size = '0;
    logic              dst_rdy = 1'b1;
    logic [NP-1:0]     acc_o, rej_o, retry_o;
    logic              busy_o;

    int unsigned cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    shbus_admit #(.NPORT(NP), .WIDTH_BITS(64), .DIV(DIV), .SZ_W(SZW)) u_shbus_admit (
        .clk        (clk),
        .rst        (rst),
        .att_vld_i  (att_vld),
        .att_req_i  (att_req),
        .att_rsp_i  (att_rsp),
        .att_dat_i  (att_dat),
        .att_size_i (att_size),
        .dst_rdy_i  (dst_rdy),
        .acc_o      (acc_o),
        .rej_o      (rej_o),
        .retry_o    (retry_o),
        .busy_o     (busy_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_in();
        att_vld = '0; att_req = '0; att_rsp = '0; att_dat = '0; att_size = '0;
    endtask

    task automatic step(input int p, input bit rq, input bit rs, input bit dt,
                        input int sz);
        @(negedge clk);
        clear_in();
        att_vld[p] = 1'b1;
        att_req[p] = rq;
        att_rsp[p] = rs;
        att_dat[p] = dt;
        att_size[p*SZW +: SZW] = SZW'(sz);
        #1;
    endtask

    task automatic step_none();
        @(negedge clk);
        clear_in();
        #1;
    endtask

    task automatic wait_idle();
        step_none();
        while (busy_o) step_none();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual 0 expected 1 completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int unsigned p, pad, expn, n;
        repeat (4) @(negedge clk);
        #1;
        chk("R13", "busy in reset", busy_o, 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R13", "busy after reset", busy_o, 0);
        chk("R13", "retry after reset", retry_o, 0);
        chk("R13", "accept idle", acc_o | rej_o, 0);

        // Occupancy table: R4, R5, R6, R12.
        for (int i = 0; i < 10; i++) begin
            wait_idle();
            if (i % 2 == 1) step_none();
            step(i % NP, TBL[i].rq, TBL[i].rs, TBL[i].dt, int'(TBL[i].sz));
            p = cyc % DIV;
            chk("R12", "table accept", acc_o, 1 << (i % NP));
            chk("R12", "table no reject", rej_o, 0);
            pad  = (p == 0) ? 0 : DIV - p;
            expn = pad + int'(TBL[i].beats) * DIV;
            step_none();
            n = 0;
            while (busy_o && n < 300) begin
                n++;
                step_none();
            end
            if (pad != 0)      chk("R6", "padded busy length", n, expn);
            else if (TBL[i].rq) chk("R4", "request busy length", n, expn);
            else               chk("R5", "data busy length", n, expn);
        end

        // Queue order, dedupe, success and timeout.
        wait_idle();
        step(0, 0, 1, 1, 64);
        chk("R12", "long transfer accepted", acc_o, 4'b0001);
        step(1, 1, 0, 0, 0);
        chk("R1", "reject while busy", rej_o, 4'b0010);
        chk("R1", "busy high", busy_o, 1);
        step(2, 1, 0, 0, 0);
        chk("R1", "second reject while busy", rej_o, 4'b0100);
        step(1, 1, 0, 0, 0);
        chk("R11", "repeat attempt rejected", rej_o, 4'b0010);
        step_none();
        while (busy_o) step_none();
        chk("R7", "strobe to head only", retry_o, 4'b0010);
        step(1, 1, 0, 0, 0);
        chk("R8", "granted resend accepted", acc_o, 4'b0010);
        chk("R7", "strobe is one cycle", retry_o, 0);
        step_none();
        while (busy_o) step_none();
        chk("R11", "second waiter strobed next", retry_o, 4'b0100);
        step_none();
        chk("R9", "silent window no strobe", retry_o, 0);
        step_none();
        chk("R11", "no duplicate entry left", retry_o, 0);
        step_none();
        chk("R9", "queue empty after timeout", retry_o, 0);
        step(2, 1, 0, 0, 0);
        chk("R9", "timed-out port admitted fresh", acc_o, 4'b0100);

        // Blocked destination and head retention.
        wait_idle();
        dst_rdy = 1'b0;
        step(3, 1, 0, 0, 0);
        chk("R3", "blocked destination rejects", rej_o, 4'b1000);
        chk("R3", "no strobe before queueing", retry_o, 0);
        step(0, 1, 0, 0, 0);
        chk("R7", "blocked port strobed", retry_o, 4'b1000);
        chk("R2", "non-granted port rejected", rej_o, 4'b0001);
        step(3, 1, 0, 0, 0);
        chk("R3", "resend rejected while blocked", rej_o, 4'b1000);
        chk("R3", "no accept while blocked", acc_o, 0);
        step_none();
        chk("R10", "failed port keeps head", retry_o, 4'b1000);
        dst_rdy = 1'b1;
        step(3, 1, 0, 0, 0);
        chk("R8", "resend accepted once ready", acc_o, 4'b1000);
        step_none();
        while (busy_o) step_none();
        chk("R10", "later waiter strobed after", retry_o, 4'b0001);
        step(0, 1, 0, 0, 0);
        chk("R8", "later waiter accepted", acc_o, 4'b0001);
        wait_idle();
        chk("R13", "idle at end", busy_o, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule